// File: doc/BRIEF.md
# Serial-Programmed Eight-Channel Current-Code Controller

This block is the digital control layer of a reliability test chip with eight identical stress channels. Each channel drives a binary-weighted current source from a 7-bit code, where one code step is 200 µA and the top code gives roughly 25 mA. A host programs the codes over a four-wire serial link made of a serial clock, a data input, a load strobe and a data output. The same link turns a global current enable on and off, and reads back the open-circuit detectors of all channels.

Each command is a 12-bit frame, sent most significant bit first. A normal session sends one write frame per channel and then turns the global enable on. The link pins and the open-circuit inputs are asynchronous to the block clock, so the block samples them with synchronizers and acts on the edges it detects. The eight codes go to the analog section as parallel buses. The global enable gates each bus.

Top module: `dac_chan_ctrl`

## Requirements
- R1: After reset every channel output is zero, the global enable is off, every stored code is zero and `sdo_o` is low.
- R2: A frame with opcode 00 stores its 7-bit payload as the code of the channel named by its address. The codes of all other channels stay unchanged.
- R3: A frame is 12 bits, most significant first: bits 11..10 are the opcode, bits 9..7 the channel address, and bits 6..0 the payload. Data is taken on each rising edge of `sclk_i`, and the frame executes on the rising edge of `sload_i`.
- R4: While the global enable is off, every channel output is zero and the stored codes are kept. Channel i appears on `dac_code_o[7*i+6:7*i]` as its stored code when the enable is on.
- R5: A frame with opcode 01 sets the global enable to payload bit 0. Its address and its other payload bits have no effect.
- R6: A load strobe that follows any number of serial clocks other than 12 since the previous strobe changes nothing.
- R7: A frame with opcode 10 captures a 16-bit status word. Bits 15..8 are the open-circuit flags, with channel 0 in bit 8. Bit 7 is the global enable and bits 6..0 are the code of the addressed channel. `sdo_o` shows bit 15 first, and each following `sclk_i` rising edge advances it by one bit.
- R8: The open-circuit inputs pass through a two-flop synchronizer, and the status word reports their settled values.
- R9: A frame with opcode 11 changes no code and does not change the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data in |
| sload_i | input | 1 | Frame load strobe |
| sdo_o | output | 1 | Serial status data out |
| open_i | input | 8 | Per-channel open-circuit detect, asynchronous |
| dac_code_o | output | 56 | Eight gated 7-bit channel codes |

## Verification
The bench sends frames of 11 and 13 bits. A design that counts bits wrongly would execute these frames and corrupt a channel code. It turns the enable off and back on with a payload whose other bits are set. A design that cleared the codes instead of gating them, or that decoded the wrong payload bit, would come back with wrong outputs. It reads the status word twice, with different flag patterns and different addressed channels. A swapped flag order, a wrong bit placement or a missing shift would show up in the serial stream.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int NCH     = 8;
  localparam int CODE_W  = 7;
  localparam int ADDR_W  = $clog2(NCH);
  localparam int OP_W    = 2;
  localparam int FRAME_W = OP_W + ADDR_W + CODE_W;
  localparam int STAT_W  = NCH + 1 + CODE_W;

  typedef enum logic [OP_W-1:0] {
    OP_WRITE = 2'b00,
    OP_ENABLE = 2'b01,
    OP_STATUS = 2'b10,
    OP_IDLE = 2'b11
  } op_e;
endpackage

// File: rtl/ser_frame_rx.sv
module ser_frame_rx #(
  parameter int FLEN = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sclk,
  input  logic            sdi,
  input  logic            sld,
  output logic            shift_o,
  output logic            frame_vld_o,
  output logic [FLEN-1:0] frame_o
);
  localparam int CW = $clog2(FLEN + 2);
  localparam logic [CW-1:0] CNT_FULL = CW'(FLEN);
  localparam logic [CW-1:0] CNT_SAT  = CW'(FLEN + 1);

  logic [2:0] s1_q, s2_q, s3_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [FLEN-1:0] sh_q, sh_d;
  logic vld_q, vld_d;
  logic sclk_rise, sld_rise;

  // two synchronizer stages plus one history stage for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= {sld, sdi, sclk};
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign sclk_rise = s2_q[0] & ~s3_q[0];
  assign sld_rise  = s2_q[2] & ~s3_q[2];

  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    vld_d = 1'b0;
    if (sld_rise) begin
      cnt_d = '0;
      vld_d = (cnt_q == CNT_FULL);
    end else if (sclk_rise) begin
      sh_d = {sh_q[FLEN-2:0], s2_q[1]};
      if (cnt_q != CNT_SAT) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      vld_q <= vld_d;
    end
  end

  assign shift_o     = sclk_rise & ~sld_rise;
  assign frame_vld_o = vld_q;
  assign frame_o     = sh_q;

  // R6: a frame is only accepted after exactly FLEN bits
  a_r6_exact_len: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld_o |-> ($past(cnt_q) == CNT_FULL && cnt_q == '0));
  a_r6_count_sat: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_SAT);
endmodule

// File: rtl/code_bank.sv
module code_bank #(
  parameter int NCH    = 8,
  parameter int CODE_W = 7,
  parameter int ADDR_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_code,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [CODE_W-1:0]     data,
  input  logic                  en_bit,
  output logic                  en_o,
  output logic [NCH*CODE_W-1:0] raw_o,
  output logic [NCH*CODE_W-1:0] dac_o
);
  logic [CODE_W-1:0] code_q [NCH];
  logic [CODE_W-1:0] code_d [NCH];
  logic en_q, en_d;

  always_comb begin
    for (int i = 0; i < NCH; i++) code_d[i] = code_q[i];
    en_d = en_q;
    if (wr_code) code_d[addr] = data;
    if (wr_en) en_d = en_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) code_q[i] <= '0;
      en_q <= 1'b0;
    end else begin
      for (int i = 0; i < NCH; i++) code_q[i] <= code_d[i];
      en_q <= en_d;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign raw_o[g*CODE_W +: CODE_W] = code_q[g];
    assign dac_o[g*CODE_W +: CODE_W] = code_q[g] & {CODE_W{en_q}};
  end
  assign en_o = en_q;

  // R2: the addressed entry takes the payload
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_code |=> (code_q[$past(addr)] == $past(data)));
  // R5: the enable follows payload bit 0
  a_r5_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (en_q == $past(en_bit)));
  // R4: stored codes survive an enable change
  a_r4_codes_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_code) |=> (raw_o == $past(raw_o)));
endmodule

// File: rtl/status_shift.sv
module status_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] word,
  input  logic         shift,
  output logic         sdo
);
  logic [W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (load) sr_d = word;
    else if (shift) sr_d = {sr_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign sdo = sr_q[W-1];

  // R7: capture and serial advance
  a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (sr_q == $past(word)));
  a_r7_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !load) |=> (sr_q == {$past(sr_q[W-2:0]), 1'b0}));
endmodule

// File: rtl/dac_chan_ctrl.sv
module dac_chan_ctrl
  import ctl_pkg::*;
#(
  parameter int N_CH  = NCH,
  parameter int CWID  = CODE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               sdi_i,
  input  logic               sload_i,
  output logic               sdo_o,
  input  logic [N_CH-1:0]    open_i,
  output logic [N_CH*CWID-1:0] dac_code_o
);
  localparam int AW = $clog2(N_CH);
  localparam int FW = OP_W + AW + CWID;
  localparam int SW = N_CH + 1 + CWID;

  logic [1:0] rst_pipe_q;
  logic rst_n;
  logic [N_CH-1:0] open_s1_q, open_s2_q;
  logic shift, frame_vld;
  logic [FW-1:0] frame;
  op_e op;
  logic [AW-1:0] addr;
  logic [CWID-1:0] payload;
  logic en;
  logic [N_CH*CWID-1:0] raw;
  logic [SW-1:0] stat_word;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= '0;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n = rst_pipe_q[1];

  // R8: open-circuit synchronizer
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      open_s1_q <= '0;
      open_s2_q <= '0;
    end else begin
      open_s1_q <= open_i;
      open_s2_q <= open_s1_q;
    end
  end

  ser_frame_rx #(.FLEN(FW)) u_rx (
    .clk(clk_i), .rst_n(rst_n), .sclk(sclk_i), .sdi(sdi_i), .sld(sload_i),
    .shift_o(shift), .frame_vld_o(frame_vld), .frame_o(frame)
  );

  assign op      = op_e'(frame[FW-1 -: OP_W]);
  assign addr    = frame[CWID +: AW];
  assign payload = frame[CWID-1:0];

  code_bank #(.NCH(N_CH), .CODE_W(CWID), .ADDR_W(AW)) u_bank (
    .clk(clk_i), .rst_n(rst_n),
    .wr_code(frame_vld && op == OP_WRITE),
    .wr_en(frame_vld && op == OP_ENABLE),
    .addr(addr), .data(payload), .en_bit(payload[0]),
    .en_o(en), .raw_o(raw), .dac_o(dac_code_o)
  );

  assign stat_word = {open_s2_q, en, raw[addr*CWID +: CWID]};

  status_shift #(.W(SW)) u_stat (
    .clk(clk_i), .rst_n(rst_n),
    .load(frame_vld && op == OP_STATUS), .word(stat_word),
    .shift(shift), .sdo(sdo_o)
  );

  // R4: outputs are dark while the enable is off
  a_r4_gated: assert property (@(posedge clk_i) disable iff (!rst_n)
    !en |-> (dac_code_o == '0));
  // R9: an idle frame leaves the bank alone
  a_r9_idle: assert property (@(posedge clk_i) disable iff (!rst_n)
    (frame_vld && op == OP_IDLE) |=> ($stable(raw) && $stable(en)));
endmodule

// File: tb/tb_dac_chan_ctrl.sv
module tb_dac_chan_ctrl;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sclk = 1'b0, sdi = 1'b0, sload = 1'b0;
  logic sdo;
  logic [7:0] open_in = 8'h00;
  logic [55:0] dac;

  int checks = 0;
  int errors = 0;
  logic [6:0] m_code [8];
  logic m_en = 1'b0;

  always #5 clk = ~clk;

  dac_chan_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .sdi_i(sdi),
    .sload_i(sload), .sdo_o(sdo), .open_i(open_in), .dac_code_o(dac)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [55:0] exp_dac();
    logic [55:0] v = '0;
    for (int i = 0; i < 8; i++) v[i*7 +: 7] = m_en ? m_code[i] : 7'd0;
    return v;
  endfunction

  task automatic send(input logic [15:0] bits, input int n, output logic [15:0] cap);
    cap = '0;
    for (int i = 0; i < n; i++) begin
      sdi = bits[n-1-i];
      wait_clk(4);
      cap = {cap[14:0], sdo};
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
    end
    wait_clk(4);
    sload = 1'b1;
    wait_clk(4);
    sload = 1'b0;
    wait_clk(10);
  endtask

  task automatic frame(input logic [1:0] op, input logic [2:0] a, input logic [6:0] p);
    logic [15:0] c;
    send({4'h0, op, a, p}, 12, c);
  endtask

  task automatic t_reset();
    check("R1 outputs", dac, 56'd0);
    check("R1 sdo", sdo, 1'b0);
  endtask

  task automatic t_write_gate();
    frame(2'b00, 3'd3, 7'h55); m_code[3] = 7'h55;
    frame(2'b00, 3'd0, 7'h7F); m_code[0] = 7'h7F;
    frame(2'b00, 3'd7, 7'h01); m_code[7] = 7'h01;
    check("R4 gated while off", dac, exp_dac());
    frame(2'b01, 3'd5, 7'h01); m_en = 1'b1;
    check("R2 R3 R5 codes appear", dac, exp_dac());
    check("R2 ch3 field", dac[27:21], 7'h55);
    frame(2'b01, 3'd2, 7'h7E); m_en = 1'b0;
    check("R5 bit0 clear disables", dac, 56'd0);
    frame(2'b01, 3'd0, 7'h03); m_en = 1'b1;
    check("R4 codes retained", dac, exp_dac());
  endtask

  task automatic t_length();
    logic [15:0] c;
    send({4'h0, 2'b00, 3'd1, 7'h2A}, 11, c);
    check("R6 short frame", dac, exp_dac());
    send({3'h0, 2'b00, 3'd1, 7'h2A, 1'b1}, 13, c);
    check("R6 long frame", dac, exp_dac());
  endtask

  task automatic t_idle();
    frame(2'b11, 3'd3, 7'h00);
    check("R9 idle", dac, exp_dac());
  endtask

  task automatic t_read(input logic [7:0] flags, input logic [2:0] a);
    logic [15:0] c;
    open_in = flags;
    wait_clk(5);
    frame(2'b10, a, 7'h00);
    send(16'hFFFF, 16, c); // 16 clocks: read out, strobe ignored (R6)
    check("R7 R8 status word", c, {flags, m_en, m_code[a]});
    check("R6 readout frame ignored", dac, exp_dac());
  endtask

  initial begin
    for (int i = 0; i < 8; i++) m_code[i] = '0;
    wait_clk(3);
    t_reset();
    rst_ni = 1'b1;
    wait_clk(5);
    t_reset();
    t_write_gate();
    t_length();
    t_idle();
    t_read(8'hA1, 3'd3);
    frame(2'b01, 3'd0, 7'h00); m_en = 1'b0;
    t_read(8'h5A, 3'd0);
    check("R4 off after read", dac, 56'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule